// File: doc/BRIEF.md
# Character I/O Flags and Interrupt Unit

This block sits between the processor datapath and two simple character devices, one that produces characters and one that consumes them. It keeps a character register and a ready flag for each direction, an interrupt-enable flag and an interrupt-request flip-flop. The sequencer presents the current timing state and, while an I/O instruction executes, a strobe together with instruction-register bits 11..6. The unit answers with the AC low-byte load, the program-counter skip and the new state of its flags.

A device hands in a character with a one-cycle valid pulse, accepted only while the input flag is clear. The output side presents its character while the output flag is clear, and the device raises an acknowledge once it has taken it. When interrupts are enabled and either flag is set late in an instruction, the request flip-flop is set. The sequencer then runs a three-state hardware branch-and-save in place of a fetch. It stores PC at address 0, sets PC to 1, and the unit drops both the enable and the request.

Top module: `chario_irq_unit`

## Requirements
- R1: After reset the input flag is 0 (`in_ready`=1), the output flag is 1 (`out_valid`=0), `int_enable`=0, `irq_cycle`=0, and both character registers are 0.
- R2: `in_valid` while the input flag is 0 loads `in_data` into the input register and sets the input flag at that clock edge; `in_ready` is the inverse of the input flag.
- R3: `in_valid` while the input flag is 1 leaves the input register and flag unchanged, and `overrun` is 1 in that same cycle.
- R4: `io_exec` with `ir_sel[5]` (IR bit 11, input character) raises `ac_lo_load` in the same cycle, with `in_char` holding the input register, and clears the input flag at the edge.
- R5: `io_exec` with `ir_sel[4]` (IR bit 10, output character) loads `ac_lo` into the output register and clears the output flag; `out_ack` sets the output flag only while it is 0, and an output command in the same cycle takes precedence; `out_valid` is the inverse of the output flag.
- R6: `pc_skip` is 1 in the cycle of `io_exec` when `ir_sel[3]` (IR bit 9) is set with the input flag at 1, or `ir_sel[2]` (IR bit 8) is set with the output flag at 1.
- R7: `io_exec` with `ir_sel[1]` (IR bit 7) sets the enable flag, and with `ir_sel[0]` (IR bit 6) clears it; when both bits are set, the clear wins.
- R8: At a clock edge where the enable flag is 1, either device flag is 1 and `t_state` is 3 or greater, `irq_cycle` becomes 1.
- R9: While `irq_cycle` is 1, `t_state`=0 raises `int_ar_clr` and `int_tr_ld`; `t_state`=1 raises `int_mem_wr` and `int_pc_clr`; `t_state`=2 raises `int_pc_inc` and `int_sc_clr`, and that edge clears both `irq_cycle` and `int_enable`.
- R10: While `irq_cycle` is 0 every interrupt-cycle control is 0, and with `io_exec` at 0 no I/O instruction effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t_state | input | T_W | Current sequence-counter value |
| io_exec | input | 1 | An I/O instruction executes this cycle |
| ir_sel | input | 6 | Instruction-register bits 11..6 |
| ac_lo | input | DATA_W | Accumulator low bits |
| in_valid | input | 1 | Input device offers a character |
| in_data | input | DATA_W | Character from the input device |
| in_ready | output | 1 | Input register is free |
| overrun | output | 1 | Offered character was dropped |
| in_char | output | DATA_W | Input register contents, for AC |
| ac_lo_load | output | 1 | Load `in_char` into AC low bits |
| out_valid | output | 1 | Output register holds an unconsumed character |
| out_data | output | DATA_W | Output register contents |
| out_ack | input | 1 | Output device has consumed the character |
| pc_skip | output | 1 | Advance PC by one |
| int_enable | output | 1 | Interrupt-enable flag |
| irq_cycle | output | 1 | Interrupt request; run the interrupt cycle |
| int_ar_clr | output | 1 | Interrupt state 0: clear AR |
| int_tr_ld | output | 1 | Interrupt state 0: TR takes PC |
| int_mem_wr | output | 1 | Interrupt state 1: memory at AR takes TR |
| int_pc_clr | output | 1 | Interrupt state 1: clear PC |
| int_pc_inc | output | 1 | Interrupt state 2: increment PC |
| int_sc_clr | output | 1 | Interrupt state 2: clear sequence counter |

## Verification
The assertions take for granted that `io_exec` appears only in state 3 of an ordinary instruction. They also assume that, once `irq_cycle` is set, the sequencer walks states 0, 1 and 2 in order before `t_state` moves on. The bench enforces both assumptions with its own sequence counter. The counter wraps after state 5 and clears when the reference model asks for it, and it raises `io_exec` only in state 3. Device pulses arrive at random, so they hit both free and full registers and land in the same cycle as instructions.

// File: rtl/chario_pkg.sv
`timescale 1ns/1ps
package chario_pkg;

   localparam int SEL_W = 6;

   typedef struct packed {
      logic get_char;
      logic put_char;
      logic skip_in;
      logic skip_out;
      logic irq_on;
      logic irq_off;
   } io_cmd_t;

   function automatic io_cmd_t decode_io(input logic [SEL_W-1:0] sel, input logic en);
      io_cmd_t c;
      c.get_char = en & sel[5];
      c.put_char = en & sel[4];
      c.skip_in  = en & sel[3];
      c.skip_out = en & sel[2];
      c.irq_on   = en & sel[1];
      c.irq_off  = en & sel[0];
      return c;
   endfunction

endpackage

// File: rtl/chario_in_port.sv
`timescale 1ns/1ps
module chario_in_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_valid,
   input  logic [DATA_W-1:0] dev_data,
   input  logic              take,
   output logic              flag,
   output logic [DATA_W-1:0] data_q,
   output logic              dropped
);

   generate
      if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
         $error("chario_in_port: DATA_W out of range");
      end
   endgenerate

   logic accept;
   assign accept  = dev_valid & ~flag;
   assign dropped = dev_valid & flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         data_q <= '0;
      end else begin
         if (accept) data_q <= dev_data;
         if (take)        flag <= 1'b0;
         else if (accept) flag <= 1'b1;
      end
   end

   p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && dev_valid) |=> (data_q == $past(data_q)));

   p_accept_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && !flag && !take) |=> (flag && data_q == $past(dev_data)));

   p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !flag);

endmodule

// File: rtl/chario_out_port.sv
`timescale 1ns/1ps
module chario_out_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              dev_ack,
   output logic              flag,
   output logic [DATA_W-1:0] data_q
);

   generate
      if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
         $error("chario_out_port: DATA_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b1;
         data_q <= '0;
      end else begin
         if (load) begin
            data_q <= load_data;
            flag   <= 1'b0;
         end else if (dev_ack && !flag) begin
            flag <= 1'b1;
         end
      end
   end

   p_load_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!flag && data_q == $past(load_data)));

   p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack && !load) |=> flag);

endmodule

// File: rtl/chario_irq_ctrl.sv
`timescale 1ns/1ps
module chario_irq_ctrl #(
   parameter int T_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [T_W-1:0] t_state,
   input  logic           irq_on,
   input  logic           irq_off,
   input  logic           flag_in,
   input  logic           flag_out,
   output logic           ien,
   output logic           req,
   output logic           st_save,
   output logic           st_write,
   output logic           st_exit
);

   generate
      if (T_W < 2) begin : g_bad_tw
         $error("chario_irq_ctrl: T_W must cover states 0..3");
      end
   endgenerate

   localparam logic [T_W-1:0] ST0 = T_W'(0);
   localparam logic [T_W-1:0] ST1 = T_W'(1);
   localparam logic [T_W-1:0] ST2 = T_W'(2);

   logic late_state;
   logic want;
   assign late_state = (t_state > ST2);
   assign want       = ien & (flag_in | flag_out) & late_state;

   assign st_save  = req & (t_state == ST0);
   assign st_write = req & (t_state == ST1);
   assign st_exit  = req & (t_state == ST2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien <= 1'b0;
         req <= 1'b0;
      end else begin
         if (st_exit)      ien <= 1'b0;
         else if (irq_off) ien <= 1'b0;
         else if (irq_on)  ien <= 1'b1;

         if (st_exit)   req <= 1'b0;
         else if (want) req <= 1'b1;
      end
   end

   p_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ien && (flag_in || flag_out) && t_state >= 3) |=> req);

   p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && t_state == 2) |=> (!req && !ien));

   p_steps_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_save, st_write, st_exit}));

   p_off_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_off |=> !ien);

   p_on_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_on && !irq_off && !st_exit) |=> ien);

endmodule

// File: rtl/chario_irq_unit.sv
`timescale 1ns/1ps
module chario_irq_unit
   import chario_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int T_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [T_W-1:0]    t_state,
   input  logic              io_exec,
   input  logic [5:0]        ir_sel,
   input  logic [DATA_W-1:0] ac_lo,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              overrun,
   output logic [DATA_W-1:0] in_char,
   output logic              ac_lo_load,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ack,
   output logic              pc_skip,
   output logic              int_enable,
   output logic              irq_cycle,
   output logic              int_ar_clr,
   output logic              int_tr_ld,
   output logic              int_mem_wr,
   output logic              int_pc_clr,
   output logic              int_pc_inc,
   output logic              int_sc_clr
);

   io_cmd_t cmd;
   logic    fgi, fgo;
   logic    s_save, s_write, s_exit;

   assign cmd = decode_io(ir_sel, io_exec);

   chario_in_port #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n),
      .dev_valid(in_valid), .dev_data(in_data),
      .take(cmd.get_char),
      .flag(fgi), .data_q(in_char), .dropped(overrun)
   );

   chario_out_port #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .load(cmd.put_char), .load_data(ac_lo),
      .dev_ack(out_ack),
      .flag(fgo), .data_q(out_data)
   );

   chario_irq_ctrl #(.T_W(T_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .t_state(t_state),
      .irq_on(cmd.irq_on), .irq_off(cmd.irq_off),
      .flag_in(fgi), .flag_out(fgo),
      .ien(int_enable), .req(irq_cycle),
      .st_save(s_save), .st_write(s_write), .st_exit(s_exit)
   );

   assign in_ready   = ~fgi;
   assign out_valid  = ~fgo;
   assign ac_lo_load = cmd.get_char;
   assign pc_skip    = (cmd.skip_in & fgi) | (cmd.skip_out & fgo);

   assign int_ar_clr = s_save;
   assign int_tr_ld  = s_save;
   assign int_mem_wr = s_write;
   assign int_pc_clr = s_write;
   assign int_pc_inc = s_exit;
   assign int_sc_clr = s_exit;

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_cycle |-> !(int_ar_clr || int_mem_wr || int_pc_inc));

   p_no_exec_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !io_exec |-> !(ac_lo_load || pc_skip));

   p_skip_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pc_skip |-> (in_ready == 1'b0 || out_valid == 1'b0));

endmodule

// File: tb/chario_irq_unit_tb.sv
`timescale 1ns/1ps
module chario_irq_unit_tb;

   localparam int DW = 8;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] t_state = '0;
   logic          io_exec = 1'b0;
   logic [5:0]    ir_sel = '0;
   logic [DW-1:0] ac_lo = '0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_ack = 1'b0;
   logic          in_ready, overrun, ac_lo_load, out_valid, pc_skip;
   logic [DW-1:0] in_char, out_data;
   logic          int_enable, irq_cycle;
   logic          int_ar_clr, int_tr_ld, int_mem_wr, int_pc_clr, int_pc_inc, int_sc_clr;

   always #4 clk = ~clk;

   chario_irq_unit #(.DATA_W(DW), .T_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .t_state(t_state), .io_exec(io_exec),
      .ir_sel(ir_sel), .ac_lo(ac_lo), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .overrun(overrun), .in_char(in_char),
      .ac_lo_load(ac_lo_load), .out_valid(out_valid), .out_data(out_data),
      .out_ack(out_ack), .pc_skip(pc_skip), .int_enable(int_enable),
      .irq_cycle(irq_cycle), .int_ar_clr(int_ar_clr), .int_tr_ld(int_tr_ld),
      .int_mem_wr(int_mem_wr), .int_pc_clr(int_pc_clr),
      .int_pc_inc(int_pc_inc), .int_sc_clr(int_sc_clr)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int irq_seen = 0;

   // behavioural reference state
   int m_fgi, m_fgo, m_ien, m_r, m_inreg, m_outreg;

   task automatic chk(input string tag, input string name, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fgi <= 0; m_fgo <= 1; m_ien <= 0; m_r <= 0; m_inreg <= 0; m_outreg <= 0;
         t_state <= '0;
      end else begin
         int nfgi, nfgo, nien, nr;
         int t;
         t = int'(t_state);
         nfgi = m_fgi; nfgo = m_fgo; nien = m_ien; nr = m_r;
         if (in_valid && m_fgi == 0) begin m_inreg <= int'(in_data); nfgi = 1; end
         if (io_exec && ir_sel[5]) nfgi = 0;
         if (io_exec && ir_sel[4]) begin m_outreg <= int'(ac_lo); nfgo = 0; end
         else if (out_ack && m_fgo == 0) nfgo = 1;
         if (m_r == 1 && t == 2) nien = 0;
         else if (io_exec && ir_sel[0]) nien = 0;
         else if (io_exec && ir_sel[1]) nien = 1;
         if (m_r == 1 && t == 2) nr = 0;
         else if (m_ien == 1 && (m_fgi == 1 || m_fgo == 1) && t >= 3) nr = 1;
         m_fgi <= nfgi; m_fgo <= nfgo; m_ien <= nien; m_r <= nr;
         if ((m_r == 1 && t == 2) || t == 5) t_state <= '0;
         else t_state <= t_state + 1'b1;
      end
   end

   task automatic compare_all();
      int t;
      t = int'(t_state);
      chk("R2", "in_ready", int'(in_ready), (m_fgi == 0) ? 1 : 0);
      chk("R2", "in_char", int'(in_char), m_inreg);
      chk("R3", "overrun", int'(overrun), (in_valid && m_fgi == 1) ? 1 : 0);
      chk("R4", "ac_lo_load", int'(ac_lo_load), (io_exec && ir_sel[5]) ? 1 : 0);
      chk("R5", "out_valid", int'(out_valid), (m_fgo == 0) ? 1 : 0);
      chk("R5", "out_data", int'(out_data), m_outreg);
      chk("R6", "pc_skip", int'(pc_skip),
          (io_exec && ((ir_sel[3] && m_fgi == 1) || (ir_sel[2] && m_fgo == 1))) ? 1 : 0);
      chk("R7", "int_enable", int'(int_enable), m_ien);
      chk("R8", "irq_cycle", int'(irq_cycle), m_r);
      chk("R9 R10", "int_ar_clr", int'(int_ar_clr), (m_r == 1 && t == 0) ? 1 : 0);
      chk("R9 R10", "int_tr_ld", int'(int_tr_ld), (m_r == 1 && t == 0) ? 1 : 0);
      chk("R9 R10", "int_mem_wr", int'(int_mem_wr), (m_r == 1 && t == 1) ? 1 : 0);
      chk("R9 R10", "int_pc_clr", int'(int_pc_clr), (m_r == 1 && t == 1) ? 1 : 0);
      chk("R9 R10", "int_pc_inc", int'(int_pc_inc), (m_r == 1 && t == 2) ? 1 : 0);
      chk("R9 R10", "int_sc_clr", int'(int_sc_clr), (m_r == 1 && t == 2) ? 1 : 0);
      if (m_r == 1 && t == 0) irq_seen++;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "in_ready", int'(in_ready), 1);
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "int_enable", int'(int_enable), 0);
      chk("R1", "irq_cycle", int'(irq_cycle), 0);
      chk("R1", "in_char", int'(in_char), 0);
      chk("R1", "out_data", int'(out_data), 0);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         @(negedge clk);
         // device side, random
         in_valid = ($urandom % 4) == 0;
         in_data  = DW'($urandom);
         out_ack  = ($urandom % 5) == 0;
         ac_lo    = DW'($urandom);
         // I/O instruction only in state 3 of a normal instruction
         io_exec = 1'b0;
         ir_sel  = '0;
         if (t_state == 4'd3 && m_r == 0 && ($urandom % 2) == 0) begin
            io_exec = 1'b1;
            if (($urandom % 8) == 0) ir_sel = 6'($urandom);
            else if (cyc < 1500) ir_sel = 6'(1 << ($urandom % 6));
            else if (($urandom % 3) == 0) ir_sel = 6'b000011; // R7 both bits, clear wins
            else ir_sel = 6'(1 << ($urandom % 6));
         end
         #1;
         compare_all();
      end
      chk("R9", "interrupt cycles observed", (irq_seen > 0) ? 1 : 0, 1);
      done = 1;
      finish_run();
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

endmodule